// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block moves received Ethernet frames from a byte stream into system memory through a ring of descriptors. Each descriptor takes two 32-bit words. The first word holds the buffer address. Its bit 0 is the ownership flag and its bit 1 is the ring-end flag. The second word is a status word that the block fills in. Every buffer is 128 bytes long, so a longer frame is spread over consecutive descriptors. When the block passes a descriptor that carries the ring-end flag, it continues at the programmed ring base.

The block has a plain word-wide memory port. It drives request, write enable, address and write data, and read data comes back one cycle after a read request. A descriptor is fetched only when stream data is waiting. Once its buffer is full or the frame has ended, the block writes the status word and then sets the ownership flag in the address word. Software takes the buffer from that point and returns it by clearing bit 0. When the block reaches a descriptor that still belongs to software, it discards the rest of the frame and raises a one-cycle pulse.

Top module: `rxd_ring_writer`

## Requirements
- R1: Byte j of a buffer is stored at buffer address + j, little-endian within a word (byte j goes to bits 8*(j mod 4)+7 down to 8*(j mod 4)). Stream bytes are accepted only while `in_ready` is high.
- R2: A buffer holds at most 128 bytes. Data writes stay inside the 128 bytes that start at the buffer address. A longer frame continues at offset 0 of the next descriptor's buffer.
- R3: Bit 0 of a fetched address word set to 0 means the buffer may be filled. The data address is that word with bits 1:0 forced to zero.
- R4: When a buffer is finished, the status word is written at descriptor address + 4. In the following cycle the address word is rewritten at the descriptor address, with bit 0 set and bits 31:1 unchanged.
- R5: Status bit 14 is set only in the buffer that holds the frame's first byte. Status bit 15 is set only in the buffer that holds its last byte.
- R6: Status bits 11:0 hold the total frame length in bytes in the buffer that holds the last byte, and zero in every other buffer.
- R7: In the last buffer of a frame, status bit 31 is the broadcast flag, bits 26, 25, 24 and 23 are `in_match[0]`..`in_match[3]`, and bit 22 is the type-ID flag, all sampled with the last byte. These bits are zero in every other buffer.
- R8: The descriptor after one whose address word has bit 1 set is read from `queue_base`. Otherwise it is read from the current descriptor address + 8. A frame may continue across this wrap.
- R9: If the descriptor needed for more data has bit 0 set, `bna_pulse` is high for exactly one cycle. The remaining bytes of the frame are accepted and discarded, and the next frame starts at that same descriptor.
- R10: While `rx_en` is low and no frame is in progress, `in_ready` and `mem_req` stay low and the descriptor pointer is reloaded from `queue_base`.
- R11: `frame_done` pulses for one cycle after the last descriptor of a frame that was stored in full has been handed back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; while low the pointer reloads from the ring base |
| queue_base | input | 32 | Byte address of the first descriptor of the ring |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_bcast | input | 1 | Broadcast destination flag, sampled with the last byte |
| in_match | input | 4 | Specific-address match flags 1..4, sampled with the last byte |
| in_typeid | input | 1 | Type-ID match flag, sampled with the last byte |
| in_ready | output | 1 | Byte accepted at the clock edge when high together with `in_valid` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| bna_pulse | output | 1 | One-cycle pulse: no free buffer, rest of the frame dropped |
| frame_done | output | 1 | One-cycle pulse: a complete frame has been handed back |

## Verification
The assertions assume a well-formed stream: every frame starts with `in_sof`, ends with `in_eof` and is no longer than 4095 bytes. They also assume that `rx_en` changes only between frames and that memory answers every read in the next cycle without stalling. The bench drives only whole frames through a ready handshake, with random gaps between bytes. It returns descriptors and toggles `rx_en` only while the block is idle. Its memory model responds after a fixed single cycle.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_CHK,
        S_RECV,
        S_WDAT,
        S_WSTAT,
        S_WADDR,
        S_DROP
    } rxd_state_e;

    typedef struct packed {
        logic       bcast;
        logic [3:0] match;
        logic       typeid;
    } rxd_flags_t;

endpackage

// File: rtl/rxd_lane_pack.sv
module rxd_lane_pack (
    input  logic [31:0] word_i,
    input  logic [7:0]  byte_i,
    input  logic [1:0]  lane_i,
    output logic [31:0] word_o
);
    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign word_o[8*g +: 8] = (lane_i == 2'(g)) ? byte_i : word_i[8*g +: 8];
    end
endmodule

// File: rtl/rxd_status_fmt.sv
module rxd_status_fmt #(
    parameter int LEN_W = 12
) (
    input  logic             first_i,
    input  logic             last_i,
    input  logic [LEN_W-1:0] len_i,
    input  rxd_pkg::rxd_flags_t flags_i,
    output logic [31:0]      status_o
);
    always_comb begin
        status_o = '0;
        status_o[14] = first_i;
        status_o[15] = last_i;
        if (last_i) begin
            status_o[11:0] = 12'(len_i);
            status_o[31]   = flags_i.bcast;
            status_o[26]   = flags_i.match[0];
            status_o[25]   = flags_i.match[1];
            status_o[24]   = flags_i.match[2];
            status_o[23]   = flags_i.match[3];
            status_o[22]   = flags_i.typeid;
        end
    end
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer #(
    parameter int BUF_BYTES  = 128,
    parameter int LEN_W      = 12,
    parameter int DESC_BYTES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_en,
    input  logic [31:0] queue_base,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic        in_bcast,
    input  logic [3:0]  in_match,
    input  logic        in_typeid,
    output logic        in_ready,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        bna_pulse,
    output logic        frame_done
);
    import rxd_pkg::*;

    localparam int CNT_W = $clog2(BUF_BYTES) + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BUF_BYTES);

    typedef struct packed {
        rxd_state_e       state;
        logic [31:0]      ptr;
        logic [31:0]      bufa;
        logic             wrap;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W-1:0] flen;
        logic [31:0]      word;
        logic             head;
        logic             tail;
        rxd_flags_t       flags;
        logic             bna;
        logic             done;
    } st_t;

    st_t q, d;

    logic [31:0]      packed_word;
    logic [31:0]      status_word;
    logic [CNT_W-1:0] last_idx;
    rxd_flags_t       in_flags;

    assign in_flags = '{bcast: in_bcast, match: in_match, typeid: in_typeid};
    assign last_idx = q.cnt - CNT_W'(1);

    rxd_lane_pack u_pack (
        .word_i (q.word),
        .byte_i (in_data),
        .lane_i (q.cnt[1:0]),
        .word_o (packed_word)
    );

    rxd_status_fmt #(.LEN_W(LEN_W)) u_stat (
        .first_i  (q.head),
        .last_i   (q.tail),
        .len_i    (q.flen),
        .flags_i  (q.flags),
        .status_o (status_word)
    );

    always_comb begin
        d         = q;
        d.bna     = 1'b0;
        d.done    = 1'b0;
        in_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (q.state)
            S_IDLE: begin
                if (!rx_en) d.ptr = queue_base;
                else if (in_valid) d.state = S_FETCH;
            end
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.ptr;
                d.state  = S_CHK;
            end
            S_CHK: begin
                if (mem_rdata[0]) begin
                    d.bna   = 1'b1;
                    d.state = S_DROP;
                end else begin
                    d.bufa  = {mem_rdata[31:2], 2'b00};
                    d.wrap  = mem_rdata[1];
                    d.state = S_RECV;
                end
            end
            S_RECV: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.word = packed_word;
                    d.cnt  = q.cnt + CNT_W'(1);
                    if (in_sof) begin
                        d.flen = LEN_W'(1);
                        d.head = 1'b1;
                    end else begin
                        d.flen = q.flen + LEN_W'(1);
                    end
                    if (in_eof) begin
                        d.tail  = 1'b1;
                        d.flags = in_flags;
                    end
                    if (q.cnt[1:0] == 2'd3 || in_eof) d.state = S_WDAT;
                end
            end
            S_WDAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.bufa + 32'({last_idx[CNT_W-1:2], 2'b00});
                mem_wdata = q.word;
                d.word    = '0;
                d.state   = (q.tail || q.cnt == FULL_CNT) ? S_WSTAT : S_RECV;
            end
            S_WSTAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.ptr + 32'd4;
                mem_wdata = status_word;
                d.state   = S_WADDR;
            end
            S_WADDR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.ptr;
                mem_wdata = {q.bufa[31:2], q.wrap, 1'b1};
                d.ptr     = q.wrap ? queue_base : q.ptr + 32'(DESC_BYTES);
                d.cnt     = '0;
                d.head    = 1'b0;
                if (q.tail) begin
                    d.tail  = 1'b0;
                    d.flags = '0;
                    d.done  = 1'b1;
                    d.state = S_IDLE;
                end else begin
                    d.state = S_FETCH;
                end
            end
            S_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_eof) begin
                    d.head  = 1'b0;
                    d.state = S_IDLE;
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bna_pulse  = q.bna;
    assign frame_done = q.done;

    // Handback order: status word must precede the ownership write.
    assert_status_before_own_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_addr == q.ptr)
        |-> $past(mem_req && mem_we && mem_addr == q.ptr + 32'd4));

    assert_data_in_buffer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && q.state == S_WDAT)
        |-> ((mem_addr - q.bufa) < 32'(BUF_BYTES)));

    assert_bna_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bna_pulse |=> !bna_pulse);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_IDLE && !rx_en) |=> (q.ptr == $past(queue_base) && !mem_req));

endmodule

// File: tb/rxd_ring_writer_bench.sv
module rxd_ring_writer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NDESC      = 8;
    localparam logic [31:0] BUF_BASE = 32'h400;
    localparam int MEM_WORDS  = 1024;

    logic clk = 1'b0;
    logic rst_n, rx_en;
    logic [31:0] queue_base;
    logic in_valid, in_sof, in_eof, in_bcast, in_typeid;
    logic [7:0] in_data;
    logic [3:0] in_match;
    logic in_ready, mem_req, mem_we, bna_pulse, frame_done;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [MEM_WORDS];
    logic sw_we = 1'b0;
    logic [31:0] sw_addr = '0, sw_data = '0;

    int n_checks = 0, n_fail = 0, bna_cnt = 0, done_cnt = 0, head_idx = 0;
    bit own [NDESC];
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxd_ring_writer u_rxd_ring_writer (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .queue_base(queue_base),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_bcast(in_bcast), .in_match(in_match), .in_typeid(in_typeid),
        .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .bna_pulse(bna_pulse), .frame_done(frame_done)
    );

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        else if (sw_we)        mem[sw_addr[11:2]] <= sw_data;
        mem_rdata <= mem[mem_addr[11:2]];
    end

    always @(negedge clk) begin
        if (bna_pulse)  bna_cnt++;
        if (frame_done) done_cnt++;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] addr_word(int i);
        return (BUF_BASE + 32'(i * 128)) | ((i == NDESC - 1) ? 32'd2 : 32'd0);
    endfunction

    function automatic logic [7:0] byte_of(int id, int i);
        return 8'((id * 37 + i * 13 + (i >> 8)) & 255);
    endfunction

    // fl = {bcast, match[3:0], typeid}
    function automatic logic [31:0] exp_stat(bit first, bit last, int len, logic [5:0] fl);
        logic [31:0] s = '0;
        s[14] = first;
        s[15] = last;
        if (last) begin
            s[11:0] = 12'(len);
            s[31] = fl[5];
            s[26] = fl[1];
            s[25] = fl[2];
            s[24] = fl[3];
            s[23] = fl[4];
            s[22] = fl[0];
        end
        return s;
    endfunction

    task automatic sw_write(input logic [31:0] a, input logic [31:0] v);
        sw_addr = a; sw_data = v; sw_we = 1'b1;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic init_ring();
        for (int i = 0; i < NDESC; i++) begin
            sw_write(32'(i * 8), addr_word(i));
            sw_write(32'(i * 8 + 4), 32'd0);
            own[i] = 1'b0;
        end
        head_idx = 0;
    endtask

    task automatic release_all();
        for (int i = 0; i < NDESC; i++)
            if (own[i]) begin
                sw_write(32'(i * 8), addr_word(i));
                own[i] = 1'b0;
            end
    endtask

    task automatic send_frame(int id, int len, logic [5:0] fl);
        for (int i = 0; i < len; i++) begin
            bit ok;
            if ($urandom % 5 == 0) begin
                in_valid = 1'b0;
                repeat ($urandom % 3 + 1) @(negedge clk);
            end
            in_valid = 1'b1; in_data = byte_of(id, i);
            in_sof = (i == 0); in_eof = (i == len - 1);
            in_bcast = fl[5]; in_match = fl[4:1]; in_typeid = fl[0];
            do begin
                ok = in_ready;
                @(negedge clk);
            end while (!ok);
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic run_frame(int id, int len, logic [5:0] fl);
        int b0 = bna_cnt, d0 = done_cnt, idx = head_idx;
        int nb = (len + 127) / 128;
        bit exp_bna = 1'b0;
        send_frame(id, len, fl);
        repeat (8) @(negedge clk);
        for (int k = 0; k < nb; k++) begin
            int blen = (k == nb - 1) ? len - k * 128 : 128;
            int bad = 0;
            logic [7:0] ga = '0, ge = '0;
            if (own[idx]) begin exp_bna = 1'b1; break; end
            check(mem[idx*2+1] == exp_stat(k == 0, k == nb - 1, len, fl),
                  "R5 R6 R7 status word", mem[idx*2+1], exp_stat(k == 0, k == nb - 1, len, fl));
            check(mem[idx*2] == (addr_word(idx) | 32'd1), "R3 R4 R8 handback word",
                  mem[idx*2], addr_word(idx) | 32'd1);
            for (int j = 0; j < blen; j++) begin
                logic [31:0] a = BUF_BASE + 32'(idx * 128 + j);
                logic [7:0] g = mem[a[11:2]][8*a[1:0] +: 8];
                if (g !== byte_of(id, k * 128 + j)) begin
                    if (bad == 0) begin ga = g; ge = byte_of(id, k * 128 + j); end
                    bad++;
                end
            end
            check(bad == 0, "R1 R2 buffer bytes", 32'(ga), 32'(ge));
            own[idx] = 1'b1;
            idx = (idx + 1) % NDESC;
        end
        head_idx = idx;
        check((bna_cnt - b0) == int'(exp_bna), "R9 missing-buffer pulse", 32'(bna_cnt - b0), 32'(exp_bna));
        check((done_cnt - d0) == int'(!exp_bna), "R11 frame done pulse", 32'(done_cnt - d0), 32'(!exp_bna));
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd4242);
        rst_n = 1'b0; rx_en = 1'b0; queue_base = 32'h0;
        in_valid = 1'b0; in_data = '0; in_sof = 1'b0; in_eof = 1'b0;
        in_bcast = 1'b0; in_match = '0; in_typeid = 1'b0;
        repeat (3) @(negedge clk);
        check(!in_ready && !mem_req && !bna_pulse && !frame_done, "reset outputs R10",
              {28'd0, in_ready, mem_req, bna_pulse, frame_done}, 32'd0);
        rst_n = 1'b1;
        init_ring();
        // R10: stream data offered while disabled is not taken
        in_valid = 1'b1; in_sof = 1'b1;
        repeat (5) begin
            @(negedge clk);
            check(!in_ready && !mem_req, "R10 disabled stall", {30'd0, in_ready, mem_req}, 32'd0);
        end
        in_valid = 1'b0; in_sof = 1'b0;
        rx_en = 1'b1;
        @(negedge clk);

        // directed boundaries
        run_frame(1, 128, 6'b100000); release_all();
        run_frame(2, 129, 6'b000011); release_all();
        run_frame(3, 1,   6'b111111);
        run_frame(4, 4,   6'b010100);
        run_frame(5, 5,   6'b001010);
        run_frame(6, 300, 6'b100001); release_all();   // crosses ring end (R8)
        run_frame(7, 500, 6'b000000);
        run_frame(8, 500, 6'b011110);                   // ring now full
        run_frame(9, 200, 6'b100000);                   // R9: whole frame dropped
        release_all();
        run_frame(10, 64, 6'b000001);

        // random traffic
        for (int f = 0; f < 40; f++) begin
            run_frame(100 + f, 1 + int'($urandom % 600), 6'($urandom));
            if ($urandom % 4 != 0) release_all();
        end

        // R10: reload pointer from ring base on re-enable
        release_all();
        rx_en = 1'b0;
        repeat (4) @(negedge clk);
        head_idx = 0;
        rx_en = 1'b1;
        @(negedge clk);
        run_frame(200, 150, 6'b101010);
        check(head_idx == 2, "R10 restart at ring base", 32'(head_idx), 32'd2);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule